// File: doc/BRIEF.md
# Cross-Port Bypass Mailbox

This block connects two ports that run on unrelated clocks. Each port can hand the other a single data word directly. The word goes into a one-word mailbox register, not into queue storage. There is one mailbox per direction, so both directions can carry a word at the same time.

Port A switches the path on with a level input. Port B sees that state through an active-low indicator that is synchronized to its own clock. There is no separate valid/ready pair. Each port instead gets two existing-style flags:

- An active-low full flag, which is low while the word it sent is still unread at the far side.
- An active-high empty flag, which is high while a word waits for it.

Each flag is timed by the clock of the port that watches it. The pending and acknowledge events cross between the clock domains as toggles, each passing through two flip-flops.

Each port uses an enable and a direction bit. Direction 0 means write and direction 1 means read. A transfer happens on a rising clock edge while the enable is high. Each clock domain has its own synchronous active-high reset. The two resets are released together.

Top module: `xport_mailbox`

## Requirements
- R1: With bypass active and `a_full_n` high, an enabled Port A cycle with `a_rd`=0 captures `a_wdata`. A later enabled Port B cycle with `b_rd`=1 and `b_empty_n` high presents that word on `b_rdata` after its clock edge.
- R2: The same holds from Port B to Port A. A Port B write captures `b_wdata` while `b_byp_n` is low and `b_full_n` is high. A Port A read then delivers the word on `a_rdata`.
- R3: The sender's full flag is low on the cycle after an accepted write. It stays low until the word is read. It returns high within three sender clock cycles of the receiver's read edge.
- R4: The receiver's empty flag goes high within three receiver clock cycles of the accepted write. It is low on the receiver cycle right after the read.
- R5: A write attempted while the sender's full flag is low is ignored. The pending word is kept and delivered unchanged, and no second word becomes available.
- R6: A read attempted while the receiver's empty flag is low leaves the read data output unchanged. It changes neither port's flags.
- R7: `b_byp_n` is the inverse of `a_byp_req`, delayed through two Port B flip-flops. It changes within three Port B cycles of a change on `a_byp_req`.
- R8: While bypass is inactive, as Port A sees it from `a_byp_req` and as Port B sees it from `b_byp_n`, writes and reads on that port are ignored. Full flags stay high and empty flags stay low.
- R9: After reset, both full flags are high, both empty flags are low, `b_byp_n` is high and both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Synchronous active-high reset, Port A domain |
| a_byp_req | input | 1 | Port A level that turns bypass mode on |
| a_en | input | 1 | Port A transfer enable |
| a_rd | input | 1 | Port A direction: 1 read, 0 write |
| a_wdata | input | W | Port A outbound word |
| a_rdata | output | W | Port A inbound word register |
| a_full_n | output | 1 | Low while Port A's word waits at Port B |
| a_empty_n | output | 1 | High while a word from Port B waits for Port A |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Synchronous active-high reset, Port B domain |
| b_en | input | 1 | Port B transfer enable |
| b_rd | input | 1 | Port B direction: 1 read, 0 write |
| b_wdata | input | W | Port B outbound word |
| b_rdata | output | W | Port B inbound word register |
| b_full_n | output | 1 | Low while Port B's word waits at Port A |
| b_empty_n | output | 1 | High while a word from Port A waits for Port B |
| b_byp_n | output | 1 | Active-low bypass indicator in Port B's clock domain |

## Verification
The bench sweeps walking-one and arithmetic patterns through both directions. It uses clocks of different periods and counts cycles to bound every handshake edge. A design that dropped a toggle, or sampled the word before it was stable, would deliver a wrong or stale word, or leave a flag stuck.

Three misuse cases are covered:
- A second write while a word is pending would replace the first word if the overwrite guard were missing. It would also leave a phantom second message.
- A read of an empty mailbox could disturb the output register or move the acknowledge toggle. That would wrongly release the sender's flag.
- Traffic with bypass off must leave every flag at rest. The bench checks the B-side view only after the synchronized indicator has settled.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

    parameter int unsigned MBX_WIDTH   = 18;
    parameter int unsigned SYNC_STAGES = 2;

    typedef enum logic {
        XFER_WRITE = 1'b0,
        XFER_READ  = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic      en;
        xfer_dir_e dir;
        logic      bypass;
    } port_req_t;

    function automatic logic req_is_write(port_req_t r);
        return r.en && r.bypass && (r.dir == XFER_WRITE);
    endfunction

    function automatic logic req_is_read(port_req_t r);
        return r.en && r.bypass && (r.dir == XFER_READ);
    endfunction

endpackage

// File: rtl/xmb_sync.sv
module xmb_sync #(
    parameter int unsigned STAGES = xmb_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("xmb_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xmb_channel.sv
module xmb_channel
    import xmb_pkg::*;
#(
    parameter int unsigned W = MBX_WIDTH
) (
    input  logic         clk_s,
    input  logic         rst_s,
    input  port_req_t    s_req,
    input  logic [W-1:0] s_wdata,
    output logic         s_full_n,
    input  logic         clk_r,
    input  logic         rst_r,
    input  port_req_t    r_req,
    output logic [W-1:0] r_rdata,
    output logic         r_empty_n
);
    logic         send_tgl_q, ack_seen;
    logic         ack_tgl_q, send_seen;
    logic [W-1:0] hold_q, rdata_q;
    logic         pending, avail;
    logic         wr_try, wr_ok, rd_try, rd_ok;

    assign pending = send_tgl_q ^ ack_seen;
    assign avail   = send_seen ^ ack_tgl_q;
    assign wr_try  = req_is_write(s_req);
    assign wr_ok   = wr_try && !pending;
    assign rd_try  = req_is_read(r_req);
    assign rd_ok   = rd_try && avail;

    // sender domain: capture word, flip send toggle
    always_ff @(posedge clk_s) begin
        if (rst_s) begin
            send_tgl_q <= 1'b0;
            hold_q     <= '0;
        end else if (wr_ok) begin
            send_tgl_q <= ~send_tgl_q;
            hold_q     <= s_wdata;
        end
    end

    xmb_sync u_fwd_sync  (.clk(clk_r), .rst(rst_r), .d(send_tgl_q), .q(send_seen));
    xmb_sync u_back_sync (.clk(clk_s), .rst(rst_s), .d(ack_tgl_q),  .q(ack_seen));

    // receiver domain: load output register, flip ack toggle
    always_ff @(posedge clk_r) begin
        if (rst_r) begin
            ack_tgl_q <= 1'b0;
            rdata_q   <= '0;
        end else if (rd_ok) begin
            ack_tgl_q <= ~ack_tgl_q;
            rdata_q   <= hold_q;
        end
    end

    assign s_full_n  = ~pending;
    assign r_empty_n = avail;
    assign r_rdata   = rdata_q;

    // R3
    wr_sets_full_chk: assert property (@(posedge clk_s) disable iff (rst_s)
        wr_ok |=> !s_full_n);
    // R5
    no_overwrite_chk: assert property (@(posedge clk_s) disable iff (rst_s)
        (wr_try && !s_full_n) |=> $stable(hold_q) && !s_full_n);
    // R4
    rd_clears_empty_chk: assert property (@(posedge clk_r) disable iff (rst_r)
        rd_ok |=> !r_empty_n);
    // R6
    empty_rd_quiet_chk: assert property (@(posedge clk_r) disable iff (rst_r)
        (rd_try && !r_empty_n) |=> $stable(r_rdata));
    // R8
    idle_wr_ignored_chk: assert property (@(posedge clk_s) disable iff (rst_s)
        (s_req.en && !s_req.bypass) |=> $stable(send_tgl_q));
endmodule

// File: rtl/xport_mailbox.sv
module xport_mailbox
    import xmb_pkg::*;
#(
    parameter int unsigned W = MBX_WIDTH
) (
    input  logic         clk_a,
    input  logic         rst_a,
    input  logic         a_byp_req,
    input  logic         a_en,
    input  logic         a_rd,
    input  logic [W-1:0] a_wdata,
    output logic [W-1:0] a_rdata,
    output logic         a_full_n,
    output logic         a_empty_n,
    input  logic         clk_b,
    input  logic         rst_b,
    input  logic         b_en,
    input  logic         b_rd,
    input  logic [W-1:0] b_wdata,
    output logic [W-1:0] b_rdata,
    output logic         b_full_n,
    output logic         b_empty_n,
    output logic         b_byp_n
);
    logic      byp_at_b;
    port_req_t req_a, req_b;

    xmb_sync u_byp_sync (.clk(clk_b), .rst(rst_b), .d(a_byp_req), .q(byp_at_b));

    assign b_byp_n = ~byp_at_b;

    always_comb begin
        req_a.en     = a_en;
        req_a.dir    = xfer_dir_e'(a_rd);
        req_a.bypass = a_byp_req;
        req_b.en     = b_en;
        req_b.dir    = xfer_dir_e'(b_rd);
        req_b.bypass = byp_at_b;
    end

    xmb_channel #(.W(W)) u_a2b (
        .clk_s(clk_a), .rst_s(rst_a), .s_req(req_a), .s_wdata(a_wdata), .s_full_n(a_full_n),
        .clk_r(clk_b), .rst_r(rst_b), .r_req(req_b), .r_rdata(b_rdata), .r_empty_n(b_empty_n)
    );

    xmb_channel #(.W(W)) u_b2a (
        .clk_s(clk_b), .rst_s(rst_b), .s_req(req_b), .s_wdata(b_wdata), .s_full_n(b_full_n),
        .clk_r(clk_a), .rst_r(rst_a), .r_req(req_a), .r_rdata(a_rdata), .r_empty_n(a_empty_n)
    );

    // R7
    byp_flag_settle_chk: assert property (@(posedge clk_b) disable iff (rst_b)
        $rose(b_byp_n) |=> b_byp_n);
endmodule

// File: tb/xport_mailbox_tb.sv
module xport_mailbox_tb;
    localparam int W = 18;
    localparam logic [W-1:0] MASK = {W{1'b1}};

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_a = 1'b1, rst_b = 1'b1;
    logic a_byp_req = 1'b0, a_en = 1'b0, a_rd = 1'b0;
    logic b_en = 1'b0, b_rd = 1'b0;
    logic [W-1:0] a_wdata = '0, b_wdata = '0;
    logic [W-1:0] a_rdata, b_rdata;
    logic a_full_n, a_empty_n, b_full_n, b_empty_n, b_byp_n;

    int tests = 0, fails = 0;
    logic [W-1:0] last_b, last_a;

    always #2.5 clk_a = ~clk_a;
    always #3.5 clk_b = ~clk_b;

    xport_mailbox #(.W(W)) u_dut (
        .clk_a(clk_a), .rst_a(rst_a), .a_byp_req(a_byp_req), .a_en(a_en), .a_rd(a_rd),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_full_n(a_full_n), .a_empty_n(a_empty_n),
        .clk_b(clk_b), .rst_b(rst_b), .b_en(b_en), .b_rd(b_rd), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_full_n(b_full_n), .b_empty_n(b_empty_n), .b_byp_n(b_byp_n)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // which: 0 a_full_n, 1 a_empty_n, 2 b_full_n, 3 b_empty_n, 4 b_byp_n
    task automatic wait_flag(input int which, input logic val, input int limit, output int n);
        logic cur;
        n = 0;
        forever begin
            case (which)
                0: cur = a_full_n;
                1: cur = a_empty_n;
                2: cur = b_full_n;
                3: cur = b_empty_n;
                default: cur = b_byp_n;
            endcase
            if (cur == val || n > limit + 4) break;
            if (which == 0 || which == 1) @(negedge clk_a); else @(negedge clk_b);
            n++;
        end
    endtask

    task automatic a_cycle(input logic rd, input logic [W-1:0] d);
        @(negedge clk_a); a_en = 1'b1; a_rd = rd; a_wdata = d;
        @(negedge clk_a); a_en = 1'b0; a_rd = 1'b0;
    endtask

    task automatic b_cycle(input logic rd, input logic [W-1:0] d);
        @(negedge clk_b); b_en = 1'b1; b_rd = rd; b_wdata = d;
        @(negedge clk_b); b_en = 1'b0; b_rd = 1'b0;
    endtask

    task automatic xfer_ab(input logic [W-1:0] v);
        int n;
        a_cycle(1'b0, v);
        check(a_full_n == 1'b0, "R3 full low after write", a_full_n, 0);
        wait_flag(3, 1'b1, 3, n);
        check(n <= 3, "R4 empty_n rise bound", n, 3);
        b_cycle(1'b1, '0);
        check(b_rdata == v, "R1 A->B word", b_rdata, v);
        check(b_empty_n == 1'b0, "R4 empty low after read", b_empty_n, 0);
        wait_flag(0, 1'b1, 3, n);
        check(n <= 3, "R3 full release bound", n, 3);
        last_b = v;
    endtask

    task automatic xfer_ba(input logic [W-1:0] v);
        int n;
        b_cycle(1'b0, v);
        check(b_full_n == 1'b0, "R3 B full low after write", b_full_n, 0);
        wait_flag(1, 1'b1, 3, n);
        check(n <= 3, "R4 A empty_n rise bound", n, 3);
        a_cycle(1'b1, '0);
        check(a_rdata == v, "R2 B->A word", a_rdata, v);
        check(a_empty_n == 1'b0, "R4 A empty low after read", a_empty_n, 0);
        wait_flag(2, 1'b1, 3, n);
        check(n <= 3, "R3 B full release bound", n, 3);
        last_a = v;
    endtask

    initial begin
        int n;
        repeat (10) @(negedge clk_b);
        rst_a = 1'b0; rst_b = 1'b0;
        @(negedge clk_a);
        // R9 reset state
        check(a_full_n && b_full_n, "R9 full flags", {a_full_n, b_full_n}, 3);
        check(!a_empty_n && !b_empty_n, "R9 empty flags", {a_empty_n, b_empty_n}, 0);
        check(b_byp_n == 1'b1, "R9 bypass indicator", b_byp_n, 1);
        check(a_rdata == '0 && b_rdata == '0, "R9 read data", a_rdata ^ b_rdata, 0);

        // R8: bypass off, writes ignored on both sides
        a_cycle(1'b0, 18'h2a5a5);
        b_cycle(1'b0, 18'h15a5a);
        repeat (5) @(negedge clk_a);
        check(a_full_n && b_full_n, "R8 writes ignored when off", {a_full_n, b_full_n}, 3);
        check(!a_empty_n && !b_empty_n, "R8 nothing available", {a_empty_n, b_empty_n}, 0);

        // R7: turn bypass on
        @(negedge clk_a); a_byp_req = 1'b1;
        wait_flag(4, 1'b0, 3, n);
        check(n <= 3 && b_byp_n == 1'b0, "R7 indicator low", n, 3);

        // R1 R2 sweep: walking ones and arithmetic patterns
        for (int i = 0; i < W; i++) begin
            xfer_ab(18'd1 << i);
            xfer_ba(~(18'd1 << i) & MASK);
        end
        for (int i = 0; i < 12; i++) begin
            xfer_ab((i * 18'h0b3d7 + 18'h00123) & MASK);
            xfer_ba((i * 18'h1c9e5 + 18'h30001) & MASK);
        end

        // R5: second write while pending is ignored
        a_cycle(1'b0, 18'h11111);
        a_cycle(1'b0, 18'h22222);
        check(a_full_n == 1'b0, "R5 still pending", a_full_n, 0);
        wait_flag(3, 1'b1, 3, n);
        b_cycle(1'b1, '0);
        check(b_rdata == 18'h11111, "R5 first word kept", b_rdata, 18'h11111);
        wait_flag(0, 1'b1, 3, n);
        repeat (6) @(negedge clk_b);
        check(b_empty_n == 1'b0, "R5 no second word", b_empty_n, 0);
        last_b = 18'h11111;

        // R6: reads of empty mailboxes
        b_cycle(1'b1, '0);
        check(b_rdata == last_b, "R6 B rdata held", b_rdata, last_b);
        a_cycle(1'b1, '0);
        check(a_rdata == last_a, "R6 A rdata held", a_rdata, last_a);
        repeat (6) @(negedge clk_a);
        check(a_full_n && b_full_n && !a_empty_n && !b_empty_n, "R6 flags unchanged",
              {a_full_n, b_full_n, a_empty_n, b_empty_n}, 4'b1100);

        // R7 R8: bypass off again, B-side write ignored
        @(negedge clk_a); a_byp_req = 1'b0;
        wait_flag(4, 1'b1, 3, n);
        check(n <= 3 && b_byp_n == 1'b1, "R7 indicator high", n, 3);
        b_cycle(1'b0, 18'h3ffff);
        a_cycle(1'b0, 18'h00fff);
        repeat (6) @(negedge clk_a);
        check(b_full_n && !a_empty_n, "R8 B write ignored", {b_full_n, a_empty_n}, 2);
        check(a_full_n && !b_empty_n, "R8 A write ignored", {a_full_n, b_empty_n}, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_a);
        tests++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule